// File: doc/BRIEF.md
# Asynchronous SRAM Bus Sequencer

This block connects a clocked processor-side request port to an asynchronous static RAM. The block takes a read or write request with an address and write data. It latches the address into an address holding register and, for writes, latches the data into a data buffer register. It then runs a fixed sequence of clocked phases that drive the active-low output-enable and write-enable strobes and the drive enable of the shared memory data bus. Chip select stays asserted at all times.

Every phase lasts a parameterised number of clock cycles, so the sequence can meet the access time, setup, pulse-width and hold needs of the attached part. Each phase length is raised to at least one cycle. The sequence is built so that the address is settled before any strobe falls. The address stays put until after the strobe rises. Write data is still driven when the write strobe rises, which is the edge on which the memory stores it. The memory data bus is never driven while the memory has its outputs enabled.

When the final phase ends, the block raises a one-cycle completion pulse. For a read, the value taken from the memory appears on the read-data output in that same cycle. A request seen while a transfer is in progress, including its completion cycle, is dropped. The block accepts a new request in the first idle cycle after completion.

Top module: `sram_seq`

## Requirements
- R1: While reset is asserted and in every idle cycle, memOeN and memWeN are 1, memDataOe is 0, done is 0 and rdData is 0.
- R2: A read accepted on a clock edge holds memOeN at 1 for the SETUP_CYCLES cycles that follow. It then holds memOeN at 0 for ACCESS_CYCLES + HOLD_CYCLES cycles, and then returns it to 1.
- R3: A read stores the value on memDataIn in the last cycle of its access window. memOeN stays at 0 for HOLD_CYCLES more cycles after that. The stored value is the one later shown on rdData.
- R4: A write drives memDataOut, with memDataOe at 1, from the first cycle after acceptance. It keeps driving for SETUP_CYCLES + PULSE_CYCLES + HOLD_CYCLES cycles. memWeN stays at 1 during the first SETUP_CYCLES of these cycles.
- R5: During a write, memWeN is 0 for exactly PULSE_CYCLES consecutive cycles, starting SETUP_CYCLES + 1 cycles after acceptance.
- R6: From the cycle after acceptance to the end of the transfer, memAddr equals the address accepted with the request. During a write, memDataOut equals the accepted write data whenever memDataOe is 1. Both are unchanged in the cycle after memWeN rises.
- R7: memDataOe is never 1 in a cycle where memOeN is 0, and memOeN and memWeN are never 0 together.
- R8: done is a one-cycle pulse. For a read it comes SETUP_CYCLES + ACCESS_CYCLES + HOLD_CYCLES + 1 cycles after acceptance. For a write it comes SETUP_CYCLES + PULSE_CYCLES + HOLD_CYCLES + 1 cycles after acceptance.
- R9: reqValid is sampled only while the block is idle. A request present in any cycle of a transfer, including the done cycle, has no effect on the memory. A request held high is accepted in the first idle cycle.
- R10: memCsN is 0 in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present (sampled when idle) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | AW | Request address |
| reqWdata | input | DW | Write data |
| rdData | output | DW | Read result, valid while done is 1 on a read, else 0 |
| done | output | 1 | One-cycle completion pulse |
| memAddr | output | AW | Address to the memory |
| memCsN | output | 1 | Chip select, active low, held asserted |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memDataOut | output | DW | Data driven toward the memory data bus |
| memDataOe | output | 1 | Drive enable for memDataOut on the shared bus |
| memDataIn | input | DW | Data sensed from the memory data bus |

## Verification
The bench attaches a behavioural memory that stores data only on the rising edge of memWeN. A design that released the data drive or changed the address as the write strobe rose would store the wrong word or store into the wrong location, and a later read would show it. When output-enable is off, the memory returns all-ones, so a read that sampled outside the output-enable window returns a wrong value. The bench also keeps a request asserted with changing fields across whole transfers and the done cycle. A design that took requests while busy would disturb the address and data the bench predicts, or would store stray words. Every cycle is compared against a reference timeline, so a phase that is one cycle too long or too short shows up as a strobe mismatch.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_ACCESS,
    ST_RD_HOLD,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_FINISH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic marLoad;     // capture request address
    logic mbrFromReq;  // capture request write data
    logic mbrFromMem;  // capture memory data bus
    logic oeAct;       // output enable active
    logic weAct;       // write enable active
    logic drvAct;      // drive memory data bus
    logic showRd;      // present buffer on read-data output
  } seqStrobe_t;

  function automatic int atLeastOne(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int SETUP_CYCLES  = 2,
  parameter int ACCESS_CYCLES = 3,
  parameter int PULSE_CYCLES  = 2,
  parameter int HOLD_CYCLES   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output seqStrobe_t strobe,
  output logic       doneOut
);

  localparam int SetupLen  = atLeastOne(SETUP_CYCLES);
  localparam int AccessLen = atLeastOne(ACCESS_CYCLES);
  localparam int PulseLen  = atLeastOne(PULSE_CYCLES);
  localparam int HoldLen   = atLeastOne(HOLD_CYCLES);
  localparam int MaxLen    = maxOf(maxOf(SetupLen, AccessLen), maxOf(PulseLen, HoldLen));
  localparam int CntW      = (MaxLen < 2) ? 1 : $clog2(MaxLen);

  seqState_t       state, nextState;
  logic [CntW-1:0] phaseCnt;
  logic            phaseLast;
  logic            wasWrite;
  logic            accept;

  // remaining-cycle load value for the phase about to start
  function automatic logic [CntW-1:0] phaseReload(input seqState_t s);
    case (s)
      ST_RD_SETUP, ST_WR_SETUP: return CntW'(SetupLen - 1);
      ST_RD_ACCESS:             return CntW'(AccessLen - 1);
      ST_WR_PULSE:              return CntW'(PulseLen - 1);
      ST_RD_HOLD, ST_WR_HOLD:   return CntW'(HoldLen - 1);
      default:                  return '0;
    endcase
  endfunction

  assign phaseLast = (phaseCnt == '0);
  assign accept    = (state == ST_IDLE) && reqValid;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:      if (reqValid) nextState = reqWrite ? ST_WR_SETUP : ST_RD_SETUP;
      ST_RD_SETUP:  if (phaseLast) nextState = ST_RD_ACCESS;
      ST_RD_ACCESS: if (phaseLast) nextState = ST_RD_HOLD;
      ST_RD_HOLD:   if (phaseLast) nextState = ST_FINISH;
      ST_WR_SETUP:  if (phaseLast) nextState = ST_WR_PULSE;
      ST_WR_PULSE:  if (phaseLast) nextState = ST_WR_HOLD;
      ST_WR_HOLD:   if (phaseLast) nextState = ST_FINISH;
      ST_FINISH:    nextState = ST_IDLE;
      default:      nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      wasWrite <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state) begin
        phaseCnt <= phaseReload(nextState);
      end else if (!phaseLast) begin
        phaseCnt <= phaseCnt - 1'b1;
      end
      if (accept) begin
        wasWrite <= reqWrite;
      end
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.marLoad    = accept;
    strobe.mbrFromReq = accept && reqWrite;
    strobe.mbrFromMem = (state == ST_RD_ACCESS) && phaseLast;
    strobe.oeAct      = (state == ST_RD_ACCESS) || (state == ST_RD_HOLD);
    strobe.weAct      = (state == ST_WR_PULSE);
    strobe.drvAct     = (state == ST_WR_SETUP) || (state == ST_WR_PULSE) ||
                        (state == ST_WR_HOLD);
    strobe.showRd     = (state == ST_FINISH) && !wasWrite;
  end

  assign doneOut = (state == ST_FINISH);

endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath
  import sram_seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strobe,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic [DW-1:0] memDataIn,
  output logic [AW-1:0] memAddr,
  output logic          memCsN,
  output logic          memOeN,
  output logic          memWeN,
  output logic [DW-1:0] memDataOut,
  output logic          memDataOe,
  output logic [DW-1:0] rdData
);

  logic [AW-1:0] addrReg;
  logic [DW-1:0] bufReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (strobe.marLoad) begin
      addrReg <= reqAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufReg <= '0;
    end else if (strobe.mbrFromReq) begin
      bufReg <= reqWdata;
    end else if (strobe.mbrFromMem) begin
      bufReg <= memDataIn;
    end
  end

  assign memAddr    = addrReg;
  assign memCsN     = 1'b0;
  assign memOeN     = !strobe.oeAct;
  assign memWeN     = !strobe.weAct;
  assign memDataOut = bufReg;
  assign memDataOe  = strobe.drvAct;
  assign rdData     = strobe.showRd ? bufReg : '0;

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int AW            = 8,
  parameter int DW            = 16,
  parameter int SETUP_CYCLES  = 2,
  parameter int ACCESS_CYCLES = 3,
  parameter int PULSE_CYCLES  = 2,
  parameter int HOLD_CYCLES   = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  output logic [DW-1:0] rdData,
  output logic          done,
  output logic [AW-1:0] memAddr,
  output logic          memCsN,
  output logic          memOeN,
  output logic          memWeN,
  output logic [DW-1:0] memDataOut,
  output logic          memDataOe,
  input  logic [DW-1:0] memDataIn
);

  seqStrobe_t strobe;

  sram_seq_ctrl #(
    .SETUP_CYCLES (SETUP_CYCLES),
    .ACCESS_CYCLES(ACCESS_CYCLES),
    .PULSE_CYCLES (PULSE_CYCLES),
    .HOLD_CYCLES  (HOLD_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .strobe  (strobe),
    .doneOut (done)
  );

  sram_seq_dpath #(
    .AW(AW),
    .DW(DW)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .memDataIn (memDataIn),
    .memAddr   (memAddr),
    .memCsN    (memCsN),
    .memOeN    (memOeN),
    .memWeN    (memWeN),
    .memDataOut(memDataOut),
    .memDataOe (memDataOe),
    .rdData    (rdData)
  );

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic [DW-1:0] rdData,
  input logic          done,
  input logic [AW-1:0] memAddr,
  input logic          memOeN,
  input logic          memWeN,
  input logic [DW-1:0] memDataOut,
  input logic          memDataOe
);

  // R7: no bus drive while the memory outputs are enabled
  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> memOeN);

  // R7: output and write enables never low together
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  // R4: write strobe only while data is driven
  a_r4_we_with_drive: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDataOe);

  // R6: address and data hold across the rising write strobe
  a_r6_write_hold: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |=> ($stable(memAddr) && $stable(memDataOut) && memDataOe));

  // R2: address settled while output enable is low
  a_r2_addr_stable_read: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> $stable(memAddr));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1: read data is zero outside completion
  a_r1_rd_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (rdData == '0));

endmodule

bind sram_seq sram_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdData    (rdData),
  .done      (done),
  .memAddr   (memAddr),
  .memOeN    (memOeN),
  .memWeN    (memWeN),
  .memDataOut(memDataOut),
  .memDataOe (memDataOe)
);

// File: tb/test_sram_seq.sv
module test_sram_seq;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int S  = 2;
  localparam int A  = 3;
  localparam int P  = 2;
  localparam int H  = 1;
  localparam int RD_LAST = S + A + H + 1;
  localparam int WR_LAST = S + P + H + 1;
  localparam int WORDS = 1 << AW;

  logic          clk;
  logic          rstN;
  logic          reqValid;
  logic          reqWrite;
  logic [AW-1:0] reqAddr;
  logic [DW-1:0] reqWdata;
  logic [DW-1:0] rdData;
  logic          done;
  logic [AW-1:0] memAddr;
  logic          memCsN;
  logic          memOeN;
  logic          memWeN;
  logic [DW-1:0] memDataOut;
  logic          memDataOe;
  logic [DW-1:0] memDataIn;

  int nChecks = 0;
  int nFail   = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  sram_seq #(
    .AW(AW), .DW(DW), .SETUP_CYCLES(S), .ACCESS_CYCLES(A),
    .PULSE_CYCLES(P), .HOLD_CYCLES(H)
  ) i_sram_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdData(rdData), .done(done),
    .memAddr(memAddr), .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .memDataIn(memDataIn)
  );

  // behavioural asynchronous memory: stores on the rising write strobe
  logic [DW-1:0] sramArr [WORDS];
  logic [DW-1:0] refMem  [WORDS];

  assign memDataIn = memOeN ? '1 : sramArr[memAddr];

  always @(posedge memWeN) begin
    if (rstN === 1'b1) sramArr[memAddr] = memDataOut;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference timeline
  bit            mActive = 1'b0;
  int            mT      = 0;
  bit            mWr     = 1'b0;
  logic [AW-1:0] mAddr   = '0;
  logic [DW-1:0] mData   = '0;

  always @(posedge clk) begin
    if (rstN !== 1'b1) begin
      mActive = 1'b0;
    end else if (mActive) begin
      if (mT == (mWr ? WR_LAST : RD_LAST)) begin
        mActive = 1'b0;
        if (mWr) refMem[mAddr] = mData;
      end else begin
        mT++;
      end
    end else if (reqValid) begin
      mActive = 1'b1;
      mT      = 1;
      mWr     = reqWrite;
      mAddr   = reqAddr;
      mData   = reqWdata;
    end
  end

  bit compareOn = 1'b0;

  always @(negedge clk) begin
    if (compareOn) begin
      bit            eOe, eWe, eDrv, eDone;
      logic [DW-1:0] eRd;
      eOe   = mActive && !mWr && (mT >= S + 1) && (mT <= S + A + H);
      eWe   = mActive && mWr && (mT >= S + 1) && (mT <= S + P);
      eDrv  = mActive && mWr && (mT <= S + P + H);
      eDone = mActive && (mT == (mWr ? WR_LAST : RD_LAST));
      eRd   = (eDone && !mWr) ? refMem[mAddr] : '0;
      chk(memCsN === 1'b0, "R10 memCsN", 32'(memCsN), 0);
      chk(memOeN === !eOe, "R2 memOeN", 32'(memOeN), 32'(!eOe));
      chk(memWeN === !eWe, "R5 memWeN", 32'(memWeN), 32'(!eWe));
      chk(memDataOe === eDrv, "R4 memDataOe", 32'(memDataOe), 32'(eDrv));
      chk(done === eDone, "R8 done", 32'(done), 32'(eDone));
      chk(rdData === eRd, "R3 rdData", 32'(rdData), 32'(eRd));
      chk(!(memDataOe === 1'b1 && memOeN === 1'b0), "R7 contention",
          32'(memDataOe), 0);
      if (mActive) chk(memAddr === mAddr, "R6 memAddr", 32'(memAddr), 32'(mAddr));
      if (eDrv) chk(memDataOut === mData, "R6 memDataOut", 32'(memDataOut), 32'(mData));
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  task automatic waitDone(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (done !== 1'b1 && lat < 100);
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int lat;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(lat);
    chk(lat + 1 == WR_LAST, "R8 write latency", 32'(lat + 1), 32'(WR_LAST));
  endtask

  task automatic doRead(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                        input string tag);
    int lat;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqWdata = '0;
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(lat);
    chk(lat + 1 == RD_LAST, "R8 read latency", 32'(lat + 1), 32'(RD_LAST));
    chk(rdData === exp, tag, 32'(rdData), 32'(exp));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int lcg;
    for (int i = 0; i < WORDS; i++) begin
      sramArr[i] = DW'(i * 37 + 5);
      refMem[i]  = DW'(i * 37 + 5);
    end
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    repeat (3) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1;
    @(negedge clk);
    // R1: reset state even with a request present
    chk(memOeN === 1'b1, "R1 reset memOeN", 32'(memOeN), 1);
    chk(memWeN === 1'b1, "R1 reset memWeN", 32'(memWeN), 1);
    chk(memDataOe === 1'b0, "R1 reset memDataOe", 32'(memDataOe), 0);
    chk(done === 1'b0, "R1 reset done", 32'(done), 0);
    chk(rdData === '0, "R1 reset rdData", 32'(rdData), 0);
    chk(memCsN === 1'b0, "R10 reset memCsN", 32'(memCsN), 0);
    reqValid = 1'b0;
    compareOn = 1'b1;
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // unwritten location, then writes at the address extremes and patterns
    doRead(8'h10, DW'(16 * 37 + 5), "R3 initial content");
    doWrite(8'h00, 16'hA5A5);
    doWrite(8'hFF, 16'h5A5A);
    doWrite(8'h5A, 16'hFFFF);
    doWrite(8'hA5, 16'h0000);
    doRead(8'h00, 16'hA5A5, "R3 readback 00");
    doRead(8'hFF, 16'h5A5A, "R3 readback FF");
    doRead(8'h5A, 16'hFFFF, "R3 readback 5A");
    doRead(8'hA5, 16'h0000, "R3 readback A5");

    // R9: requests during a transfer and its done cycle are dropped
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 8'h33; reqWdata = 16'h1234;
    @(negedge clk);
    reqAddr = 8'h44; reqWdata = 16'hBEEF;
    while (done !== 1'b1) @(negedge clk);
    reqValid = 1'b0;
    doRead(8'h44, DW'(8'h44 * 37 + 5), "R9 busy write dropped");
    doRead(8'h33, 16'h1234, "R9 first write kept");

    // R9: request held high across many transfers with changing fields
    lcg = 7;
    @(negedge clk);
    for (int k = 0; k < 120; k++) begin
      lcg = lcg * 1103515245 + 12345;
      reqValid = 1'b1;
      reqWrite = lcg[20];
      reqAddr  = AW'(lcg >>> 8) & 8'h0F;
      reqWdata = DW'(lcg >>> 3);
      @(negedge clk);
    end
    reqValid = 1'b0;
    repeat (12) @(negedge clk);
    for (int j = 0; j < 4; j++) begin
      doRead(AW'(j), refMem[j], "R9 contents after held request");
    end
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule